// File: doc/BRIEF.md
# Timer Clock Source Selector

This block decides, cycle by cycle, whether a timer/counter advances. A 3-bit select input picks one of eight sources. One source stops the timer. One lets it advance every system clock. Four divide the system clock by 8, 64, 256 or 1024, using taps of a shared free-running 10-bit prescaler. The last two count falling or rising edges of an external pin. The result is a single registered enable pulse, `count_en_o`. The timer that consumes it lies outside this block.

The external pin is sampled with no regard to how the rest of the chip drives it. Software that toggles the pin as an output therefore still steps the timer. The pin passes through a two-flop synchronizer, and one more flop holds the previous sample for edge detection. A prescaler-clear strobe zeroes the prescaler, so the next divided period starts from a known phase. The interface has no data stream, so all pins are plain control pins with no handshake.

Top module: `tmr_clksel`

## Requirements
- R1: With select 3'b000 the enable output stays low.
- R2: With select 3'b001 the enable output is high in every cycle.
- R3: Select codes 3'b010, 3'b011, 3'b100 and 3'b101 give exactly one enable pulse per 8, 64, 256 and 1024 cycles. In any window whose length is a multiple of the ratio, the count is the window length divided by the ratio.
- R4: The prescaler is a 10-bit free-running counter. When a clear strobe is sampled at a clock edge, the first divided pulse appears exactly N edges later, where N is the selected ratio. The output is high after that edge and low after the N-1 edges before it.
- R5: With select 3'b110, each falling edge of the pin gives one enable pulse. If the pin changes before edge k, the output is high after edge k+2.
- R6: With select 3'b111, each rising edge of the pin gives one enable pulse, with the same latency as R5.
- R7: An enable pulse caused by a pin edge is exactly one clock wide.
- R8: A new select value is sampled at the next clock edge, and the output after that edge follows the new source. Switching into an edge mode while the pin is steady gives no pulse.
- R9: During reset and directly after it the output is low and the prescaler is zero. With a divided source held through reset, the first pulse follows N edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_i | input | 3 | Clock source select code |
| psc_clr_i | input | 1 | Prescaler clear strobe |
| pin_i | input | 1 | Raw external clock pin, asynchronous |
| count_en_o | output | 1 | Registered timer count-enable pulse |

## Verification
The assertions assume that the pin is steady for at least three clocks before reset is released. The synchronizer flops are not reset, so an earlier change could appear as an edge after reset. The edge-width and divided-source properties also assume that the select code is held across the cycles they span. The stimulus drives all inputs on falling clock edges. It holds the pin low through reset and changes the select code only between measurement windows, except in the directed tests that check switching.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    CS_OFF      = 3'b000,
    CS_DIV1     = 3'b001,
    CS_DIV8     = 3'b010,
    CS_DIV64    = 3'b011,
    CS_DIV256   = 3'b100,
    CS_DIV1024  = 3'b101,
    CS_PIN_FALL = 3'b110,
    CS_PIN_RISE = 3'b111
  } cs_sel_e;

  localparam int PSC_W  = 10;
  localparam int N_TAPS = 4;

  // log2 of the division ratio for prescaler tap i
  function automatic int tap_shift(input int i);
    case (i)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler
  import tcs_pkg::*;
#(
  parameter int W = PSC_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              clr_i,
  output logic [N_TAPS-1:0] tap_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // a tap fires on the last count of each period of its ratio
  for (genvar gi = 0; gi < N_TAPS; gi++) begin : g_tap
    localparam int SH = tap_shift(gi);
    if (SH > W) begin : g_short
      assign tap_o[gi] = 1'b0;
    end else begin : g_full
      assign tap_o[gi] = &cnt_q[SH-1:0];
    end
  end

endmodule

// File: rtl/tcs_pin_edge.sv
module tcs_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  localparam int HIST_W = SYNC_STAGES + 1;

  // no reset: the chain tracks the pin during reset so that no edge is
  // invented when reset releases
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i) begin
    hist_q <= {hist_q[HIST_W-2:0], pin_i};
  end

  assign rise_o =  hist_q[HIST_W-2] & ~hist_q[HIST_W-1];
  assign fall_o = ~hist_q[HIST_W-2] &  hist_q[HIST_W-1];

endmodule

// File: rtl/tcs_src_mux.sv
module tcs_src_mux
  import tcs_pkg::*;
(
  input  logic [2:0]        sel_i,
  input  logic [N_TAPS-1:0] tap_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              en_o
);

  cs_sel_e sel;
  assign sel = cs_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      CS_OFF:      en_o = 1'b0;
      CS_DIV1:     en_o = 1'b1;
      CS_DIV8:     en_o = tap_i[0];
      CS_DIV64:    en_o = tap_i[1];
      CS_DIV256:   en_o = tap_i[2];
      CS_DIV1024:  en_o = tap_i[3];
      CS_PIN_FALL: en_o = fall_i;
      CS_PIN_RISE: en_o = rise_i;
      default:     en_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/tmr_clksel.sv
module tmr_clksel
  import tcs_pkg::*;
#(
  parameter int PRESC_W     = PSC_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [2:0] sel_i,
  input  logic       psc_clr_i,
  input  logic       pin_i,
  output logic       count_en_o
);

  logic [N_TAPS-1:0] tap;
  logic              rise;
  logic              fall;
  logic              en_next;

  tcs_prescaler #(.W(PRESC_W)) i_presc (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .clr_i (psc_clr_i),
    .tap_o (tap)
  );

  tcs_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk_i  (clk_i),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  tcs_src_mux i_mux (
    .sel_i  (sel_i),
    .tap_i  (tap),
    .rise_i (rise),
    .fall_i (fall),
    .en_o   (en_next)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) count_en_o <= 1'b0;
    else       count_en_o <= en_next;
  end

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker (
  input logic       clk_i,
  input logic       rst_i,
  input logic [2:0] sel_i,
  input logic       psc_clr_i,
  input logic       count_en_o
);

  logic clr_d;
  always_ff @(posedge clk_i) begin
    if (rst_i) clr_d <= 1'b0;
    else       clr_d <= psc_clr_i;
  end

  logic div_sel;
  assign div_sel = (sel_i >= 3'b010) && (sel_i <= 3'b101);

  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_i == 3'b000) |=> !count_en_o); // R1

  AST_DIV1_ALWAYS: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_i == 3'b001) |=> count_en_o); // R2

  AST_CLR_NO_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_d && div_sel) |=> !count_en_o); // R4

  AST_RISE_ONE_WIDE: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_i == 3'b111 && $past(sel_i) == 3'b111 && count_en_o) |=> !count_en_o); // R7

  AST_FALL_ONE_WIDE: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_i == 3'b110 && $past(sel_i) == 3'b110 && count_en_o) |=> !count_en_o); // R7

endmodule

bind tmr_clksel tcs_checker i_tcs_checker (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .sel_i      (sel_i),
  .psc_clr_i  (psc_clr_i),
  .count_en_o (count_en_o)
);

// File: tb/test_tmr_clksel.sv
`timescale 1ns/1ps
module test_tmr_clksel;

  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic [2:0] sel_i = 3'b000;
  logic       psc_clr_i = 1'b0;
  logic       pin_i = 1'b0;
  logic       count_en_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  tmr_clksel i_tmr_clksel (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .sel_i      (sel_i),
    .psc_clr_i  (psc_clr_i),
    .pin_i      (pin_i),
    .count_en_o (count_en_o)
  );

  localparam int NVEC = 6;
  localparam int WIN  = 2048;
  localparam logic [2:0] VSEL [NVEC] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101};
  localparam int         VEXP [NVEC] = '{0, 2048, 256, 32, 8, 2};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_sample();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // clear the prescaler and count pulses over n edges
  task automatic window(input logic [2:0] s, input int n, output int cnt);
    @(negedge clk_i);
    sel_i = s;
    psc_clr_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    psc_clr_i = 1'b0;
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      step_sample();
      if (count_en_o) cnt++;
    end
  endtask

  initial begin
    #4000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    // R9: reset state with a divided source held through reset
    sel_i = 3'b010;
    repeat (5) @(posedge clk_i);
    @(negedge clk_i);
    check("R9 output low in reset", count_en_o, 0);
    rst_i = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      step_sample();
      check("R9 first div8 pulse after reset", count_en_o, (k == 8) ? 1 : 0);
    end

    // R1 R2 R3: table of sources and expected pulse totals
    for (int v = 0; v < NVEC; v++) begin
      window(VSEL[v], WIN, cnt);
      check($sformatf("R3 sel=%0d window count (R1 R2)", VSEL[v]), cnt, VEXP[v]);
    end

    // R4: first pulse exactly N edges after the clear edge
    @(negedge clk_i);
    sel_i = 3'b011;
    psc_clr_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    psc_clr_i = 1'b0;
    cnt = 0;
    for (int k = 1; k <= 64; k++) begin
      step_sample();
      if (count_en_o) begin
        if (cnt == 0) check("R4 first div64 pulse position", k, 64);
        cnt++;
      end
    end
    check("R4 div64 pulses after clear", cnt, 1);

    // R6: rising-edge latency and width
    @(negedge clk_i);
    sel_i = 3'b111;
    repeat (4) step_sample();
    pin_i = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      step_sample();
      check("R6 R7 rise latency and width", count_en_o, (k == 3) ? 1 : 0);
    end

    // R5: falling-edge latency
    sel_i = 3'b110;
    repeat (4) step_sample();
    check("R8 no pulse entering fall mode with steady pin", count_en_o, 0);
    pin_i = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      step_sample();
      check("R5 fall latency", count_en_o, (k == 3) ? 1 : 0);
    end

    // R5: count falling edges of a toggled pin
    cnt = 0;
    for (int p = 0; p < 5; p++) begin
      pin_i = 1'b1;
      repeat (3) begin step_sample(); if (count_en_o) cnt++; end
      pin_i = 1'b0;
      repeat (3) begin step_sample(); if (count_en_o) cnt++; end
    end
    repeat (5) begin step_sample(); if (count_en_o) cnt++; end
    check("R5 falling edge count", cnt, 5);

    // R6: rising edges ignored in fall mode, counted in rise mode
    sel_i = 3'b111;
    cnt = 0;
    for (int p = 0; p < 4; p++) begin
      pin_i = 1'b1;
      repeat (4) begin step_sample(); if (count_en_o) cnt++; end
      pin_i = 1'b0;
      repeat (4) begin step_sample(); if (count_en_o) cnt++; end
    end
    check("R6 rising edge count", cnt, 4);

    // R8: pin held high then switch into rise mode: no pulse
    sel_i = 3'b000;
    pin_i = 1'b1;
    repeat (6) step_sample();
    sel_i = 3'b111;
    cnt = 0;
    repeat (6) begin step_sample(); if (count_en_o) cnt++; end
    check("R8 no spurious pulse on switch", cnt, 0);

    // R8: switching takes effect after the next edge
    sel_i = 3'b001;
    step_sample();
    check("R8 div1 active after one edge", count_en_o, 1);
    sel_i = 3'b000;
    step_sample();
    check("R8 off active after one edge (R1)", count_en_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule